// File: doc/BRIEF.md
# I2C Master Control and Interrupt Flag Core

This block is the control and status core of a register-mapped I2C bus controller. It sits between the register file and a bit-level bus engine. Writes to a master-select bit are turned into single-cycle START and STOP requests for the engine. Bus-busy is tracked from START and STOP conditions that the engine sees on the lines. Byte, arbitration, addressing, no-acknowledge and bus-idle events are folded into one sticky interrupt flag.

A mode state machine owns the master-select bit. Its states are `ST_SLAVE`, `ST_START`, `ST_MASTER`, `ST_HOLD` and `ST_STOP`. Its transitions are:
- slave-to-start, on a write of 1;
- start-to-master, unconditional;
- master-to-stop, on a write of 0 with no byte in flight;
- master-to-hold, on a write of 0 while a byte is in flight;
- hold-to-stop, once the byte and its acknowledge finish;
- stop-to-slave, unconditional;
- any-to-slave, on arbitration loss, which issues no STOP.

While a byte is being shifted, a STOP is kept in `ST_HOLD`. It is passed to the engine only after the transfer-complete bit is set. Software can therefore drop the master bit at any time without cutting a byte short. In DMA mode the per-byte event still sets transfer-complete, but it does not raise the interrupt flag.

Top module: `i2c_ctl_core`

## Requirements
- R1: A write of 1 to the master bit from slave mode raises `req_start` for exactly one cycle, starting the cycle after the write, and `mode_master` reads 1 from that cycle.
- R2: A write of 0 to the master bit in master mode, with `xfer_done`=1, makes `mode_master` read 0 and raises `req_stop` for one cycle, both in the cycle after the write.
- R3: `arb_lost_ev` sets `arb_lost` and `irq_flag`, clears `mode_master` in the next cycle, and never raises `req_stop`.
- R4: After reset: `mode_master`=0, `req_start`=0, `req_stop`=0, `bus_busy`=0, `xfer_done`=1, `arb_lost`=0, `irq_flag`=0 and `irq`=0.
- R5: `irq_flag` is set by any of:
  - `byte_ack` with DMA off;
  - `addr_hit`;
  - `nack_rx` while in master mode with transmit selected;
  - a 1-to-0 change of `bus_busy` while the idle interrupt enable is 1.
- R6: With DMA on, `byte_ack` sets `xfer_done` but leaves `irq_flag` at 0.
- R7: `irq` is 1 exactly when the interrupt enable and `irq_flag` are both 1. Clearing the enable leaves a pending `irq_flag` at 1.
- R8: A status write with `stat_clr_flag`=1 clears `irq_flag`. A status write with `stat_clr_arb`=1 clears `arb_lost`. Each clear leaves the other bit unchanged.
- R9: `bus_busy` becomes 1 the cycle after `line_start` and stays 1 until the cycle after `line_stop`.
- R10: `xfer_done` goes to 0 the cycle after `byte_begin` and to 1 the cycle after `byte_ack`.
- R11: A 0 write made while `xfer_done`=0 clears `mode_master` at once. It withholds `req_stop` until the cycle after `xfer_done` becomes 1.
- R12: Writing 1 in master mode, or 0 in slave mode, produces no `req_start` and no `req_stop`.
- R13: `nack_rx` in slave mode or with receive selected leaves `irq_flag` at 0. A `bus_busy` fall with the idle enable at 0 also leaves `irq_flag` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_master | input | 1 | Master-select value written |
| ctrl_tx | input | 1 | Transmit direction select written |
| ctrl_ie | input | 1 | Interrupt enable written |
| ctrl_dma | input | 1 | DMA mode enable written |
| ctrl_idle_ie | input | 1 | Bus-idle interrupt enable written |
| stat_wr | input | 1 | Status register write strobe |
| stat_clr_flag | input | 1 | Write-1-to-clear for the interrupt flag |
| stat_clr_arb | input | 1 | Write-1-to-clear for arbitration lost |
| line_start | input | 1 | START seen on the bus (pulse) |
| line_stop | input | 1 | STOP seen on the bus (pulse) |
| byte_begin | input | 1 | Engine begins shifting a byte (pulse) |
| byte_ack | input | 1 | Acknowledge clock edge of a byte (pulse) |
| arb_lost_ev | input | 1 | Engine lost arbitration (pulse) |
| addr_hit | input | 1 | Addressed as slave (pulse) |
| nack_rx | input | 1 | No-acknowledge received (pulse) |
| req_start | output | 1 | START request to the engine |
| req_stop | output | 1 | STOP request to the engine |
| mode_master | output | 1 | Master-select bit readback |
| bus_busy | output | 1 | Bus busy status |
| xfer_done | output | 1 | Transfer-complete status |
| arb_lost | output | 1 | Arbitration-lost status |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume three things about the bus engine:
- it never starts a byte in the same cycle that software drops the master bit;
- it never starts a byte while a STOP is pending;
- event inputs are single-cycle pulses.

The bench keeps to these rules. `byte_begin` is driven only in master mode, with a quiet cycle before any mode write. Every event is driven for exactly one cycle. Mode writes are never issued while the state machine is in `ST_START` or `ST_STOP`, because those transient states ignore writes.

// File: rtl/i2c_core_pkg.sv
package i2c_core_pkg;
    typedef enum logic [2:0] {
        ST_SLAVE  = 3'd0,
        ST_START  = 3'd1,
        ST_MASTER = 3'd2,
        ST_HOLD   = 3'd3,
        ST_STOP   = 3'd4
    } mode_state_t;
endpackage

// File: rtl/i2c_mode_fsm.sv
module i2c_mode_fsm
    import i2c_core_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_wr,
    input  logic mode_val,
    input  logic arb_ev,
    input  logic byte_done,
    output logic req_start,
    output logic req_stop,
    output logic is_master
);
    mode_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SLAVE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (arb_ev) begin
            state_nx = ST_SLAVE;
        end else begin
            unique case (state)
                ST_SLAVE:  if (mode_wr && mode_val) state_nx = ST_START;
                ST_START:  state_nx = ST_MASTER;
                ST_MASTER: if (mode_wr && !mode_val)
                               state_nx = byte_done ? ST_STOP : ST_HOLD;
                ST_HOLD:   if (byte_done) state_nx = ST_STOP;
                ST_STOP:   state_nx = ST_SLAVE;
                default:   state_nx = ST_SLAVE;
            endcase
        end
    end

    always_comb begin
        req_start = 1'b0;
        req_stop  = 1'b0;
        is_master = 1'b0;
        unique case (state)
            ST_START:  begin req_start = 1'b1; is_master = 1'b1; end
            ST_MASTER: is_master = 1'b1;
            ST_STOP:   req_stop = 1'b1;
            default:   ;
        endcase
    end

    a_r1_start_in_master: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |-> is_master);
    a_r2_stop_in_slave: assert property (@(posedge clk) disable iff (!rst_n)
        req_stop |-> !is_master);
    a_r12_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_start |=> !req_start);
    a_r3_arb_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_ev && !req_stop) |=> (!is_master && !req_stop));
endmodule

// File: rtl/i2c_bus_busy.sv
module i2c_bus_busy (
    input  logic clk,
    input  logic rst_n,
    input  logic seen_start,
    input  logic seen_stop,
    output logic busy,
    output logic busy_fall
);
    logic busy_nx;

    always_comb begin
        if (seen_start)     busy_nx = 1'b1;
        else if (seen_stop) busy_nx = 1'b0;
        else                busy_nx = busy;
    end

    assign busy_fall = busy && !busy_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) busy <= 1'b0;
        else        busy <= busy_nx;
    end

    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !seen_stop) |=> busy);
    a_r9_busy_sets: assert property (@(posedge clk) disable iff (!rst_n)
        seen_start |=> busy);
endmodule

// File: rtl/i2c_xfer_track.sv
module i2c_xfer_track (
    input  logic clk,
    input  logic rst_n,
    input  logic begin_ev,
    input  logic ack_ev,
    output logic done
);
    always_ff @(posedge clk) begin
        if (!rst_n)        done <= 1'b1;
        else if (ack_ev)   done <= 1'b1;
        else if (begin_ev) done <= 1'b0;
    end

    a_r10_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_ev |=> done);
endmodule

// File: rtl/i2c_irq_flag.sv
module i2c_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic arb_ev,
    input  logic ack_ev,
    input  logic addr_ev,
    input  logic nack_ev,
    input  logic master_tx,
    input  logic dma_en,
    input  logic idle_fall,
    input  logic idle_ie,
    input  logic clr,
    output logic flag
);
    logic set_any;

    always_comb begin
        set_any = arb_ev
                | (ack_ev && !dma_en)
                | addr_ev
                | (nack_ev && master_tx)
                | (idle_fall && idle_ie);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= set_any | (flag & ~clr);
    end

    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    a_r3_arb_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        arb_ev |=> flag);
endmodule

// File: rtl/i2c_ctl_core.sv
module i2c_ctl_core (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_master,
    input  logic ctrl_tx,
    input  logic ctrl_ie,
    input  logic ctrl_dma,
    input  logic ctrl_idle_ie,
    input  logic stat_wr,
    input  logic stat_clr_flag,
    input  logic stat_clr_arb,
    input  logic line_start,
    input  logic line_stop,
    input  logic byte_begin,
    input  logic byte_ack,
    input  logic arb_lost_ev,
    input  logic addr_hit,
    input  logic nack_rx,
    output logic req_start,
    output logic req_stop,
    output logic mode_master,
    output logic bus_busy,
    output logic xfer_done,
    output logic arb_lost,
    output logic irq_flag,
    output logic irq
);
    logic tx_q, ie_q, dma_q, idle_ie_q;
    logic busy_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q      <= 1'b0;
            ie_q      <= 1'b0;
            dma_q     <= 1'b0;
            idle_ie_q <= 1'b0;
        end else if (ctrl_wr) begin
            tx_q      <= ctrl_tx;
            ie_q      <= ctrl_ie;
            dma_q     <= ctrl_dma;
            idle_ie_q <= ctrl_idle_ie;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            arb_lost <= 1'b0;
        else if (arb_lost_ev)                  arb_lost <= 1'b1;
        else if (stat_wr && stat_clr_arb)      arb_lost <= 1'b0;
    end

    i2c_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (ctrl_wr),
        .mode_val  (ctrl_master),
        .arb_ev    (arb_lost_ev),
        .byte_done (xfer_done),
        .req_start (req_start),
        .req_stop  (req_stop),
        .is_master (mode_master)
    );

    i2c_bus_busy u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .seen_start (line_start),
        .seen_stop  (line_stop),
        .busy       (bus_busy),
        .busy_fall  (busy_fall)
    );

    i2c_xfer_track u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .begin_ev (byte_begin),
        .ack_ev   (byte_ack),
        .done     (xfer_done)
    );

    i2c_irq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .arb_ev    (arb_lost_ev),
        .ack_ev    (byte_ack),
        .addr_ev   (addr_hit),
        .nack_ev   (nack_rx),
        .master_tx (mode_master && tx_q),
        .dma_en    (dma_q),
        .idle_fall (busy_fall),
        .idle_ie   (idle_ie_q),
        .clr       (stat_wr && stat_clr_flag),
        .flag      (irq_flag)
    );

    assign irq = ie_q && irq_flag;

    a_r11_stop_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        req_stop |-> xfer_done);
    a_r3_arb_bit_sets: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost_ev |=> arb_lost);
endmodule

// File: tb/i2c_ctl_core_tb.sv
`timescale 1ns/1ps
module i2c_ctl_core_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, ctrl_master = 0, ctrl_tx = 0, ctrl_ie = 0, ctrl_dma = 0, ctrl_idle_ie = 0;
    logic stat_wr = 0, stat_clr_flag = 0, stat_clr_arb = 0;
    logic line_start = 0, line_stop = 0, byte_begin = 0, byte_ack = 0;
    logic arb_lost_ev = 0, addr_hit = 0, nack_rx = 0;
    logic req_start, req_stop, mode_master, bus_busy, xfer_done, arb_lost, irq_flag, irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    logic sh_tx = 0, sh_ie = 0, sh_dma = 0, sh_idle = 0;

    always #2.5 clk = ~clk;

    i2c_ctl_core u_dut (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_master(ctrl_master), .ctrl_tx(ctrl_tx),
        .ctrl_ie(ctrl_ie), .ctrl_dma(ctrl_dma), .ctrl_idle_ie(ctrl_idle_ie),
        .stat_wr(stat_wr), .stat_clr_flag(stat_clr_flag), .stat_clr_arb(stat_clr_arb),
        .line_start(line_start), .line_stop(line_stop),
        .byte_begin(byte_begin), .byte_ack(byte_ack),
        .arb_lost_ev(arb_lost_ev), .addr_hit(addr_hit), .nack_rx(nack_rx),
        .req_start(req_start), .req_stop(req_stop), .mode_master(mode_master),
        .bus_busy(bus_busy), .xfer_done(xfer_done), .arb_lost(arb_lost),
        .irq_flag(irq_flag), .irq(irq)
    );

    task automatic chk(input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr_ctrl(input logic m);
        ctrl_wr = 1; ctrl_master = m; ctrl_tx = sh_tx; ctrl_ie = sh_ie;
        ctrl_dma = sh_dma; ctrl_idle_ie = sh_idle;
        tick();
        ctrl_wr = 0;
    endtask

    task automatic wr_stat(input logic cf, input logic ca);
        stat_wr = 1; stat_clr_flag = cf; stat_clr_arb = ca;
        tick();
        stat_wr = 0; stat_clr_flag = 0; stat_clr_arb = 0;
    endtask

    task automatic pulse_begin();
        byte_begin = 1; tick(); byte_begin = 0;
    endtask

    task automatic pulse_ack();
        byte_ack = 1; tick(); byte_ack = 0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R4 reset state
        chk("R4 mode_master", mode_master, 0);
        chk("R4 req_start", req_start, 0);
        chk("R4 req_stop", req_stop, 0);
        chk("R4 bus_busy", bus_busy, 0);
        chk("R4 xfer_done", xfer_done, 1);
        chk("R4 arb_lost", arb_lost, 0);
        chk("R4 irq_flag", irq_flag, 0);
        chk("R4 irq", irq, 0);

        // R1 start
        wr_ctrl(1);
        chk("R1 req_start", req_start, 1);
        chk("R1 mode_master", mode_master, 1);
        tick();
        chk("R1 req_start one cycle", req_start, 0);
        chk("R1 still master", mode_master, 1);

        // R12 repeated 1
        wr_ctrl(1);
        chk("R12 no start on rewrite", req_start, 0);
        tick();
        chk("R12 no start later", req_start, 0);

        // R2 stop with no byte in flight
        wr_ctrl(0);
        chk("R2 req_stop", req_stop, 1);
        chk("R2 mode_master", mode_master, 0);
        tick();
        chk("R2 req_stop one cycle", req_stop, 0);
        wr_ctrl(0);
        chk("R12 no stop on rewrite", req_stop, 0);
        tick();
        chk("R12 no stop later", req_stop, 0);

        // R11 / R10 stop held behind a byte
        wr_ctrl(1);
        tick();
        pulse_begin();
        chk("R10 xfer_done clears", xfer_done, 0);
        tick();
        wr_ctrl(0);
        chk("R11 mode drops at once", mode_master, 0);
        chk("R11 stop withheld", req_stop, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R11 stop still withheld", req_stop, 0);
        end
        pulse_ack();
        chk("R10 xfer_done sets", xfer_done, 1);
        chk("R11 no stop on ack edge", req_stop, 0);
        tick();
        chk("R11 stop after byte", req_stop, 1);
        tick();
        chk("R11 stop one cycle", req_stop, 0);
        chk("R5 ack sets flag", irq_flag, 1);
        wr_stat(1, 0);
        chk("R8 flag cleared", irq_flag, 0);

        // R3 arbitration loss
        wr_ctrl(1);
        tick();
        arb_lost_ev = 1; tick(); arb_lost_ev = 0;
        chk("R3 mode dropped", mode_master, 0);
        chk("R3 arb bit", arb_lost, 1);
        chk("R3 flag", irq_flag, 1);
        chk("R3 no stop", req_stop, 0);
        tick();
        chk("R3 no stop later", req_stop, 0);

        // R8 separate clears
        wr_stat(0, 1);
        chk("R8 arb cleared", arb_lost, 0);
        chk("R8 flag kept", irq_flag, 1);
        wr_stat(1, 0);
        chk("R8 flag cleared", irq_flag, 0);

        // R7 enable gating
        addr_hit = 1; tick(); addr_hit = 0;
        chk("R5 addr sets flag", irq_flag, 1);
        chk("R7 irq off without enable", irq, 0);
        sh_ie = 1; wr_ctrl(0);
        chk("R7 irq on", irq, 1);
        sh_ie = 0; wr_ctrl(0);
        chk("R7 irq off after disable", irq, 0);
        chk("R7 flag kept after disable", irq_flag, 1);
        wr_stat(1, 0);

        // R5 / R6 / R13 sweep in master mode
        wr_ctrl(1);
        tick();
        for (int v = 0; v < 32; v++) begin
            logic a, h, n, d, t, e;
            a = v[0]; h = v[1]; n = v[2]; d = v[3]; t = v[4];
            sh_dma = d; sh_tx = t; sh_ie = 1;
            wr_ctrl(1);
            chk("R12 sweep no start", req_start, 0);
            pulse_begin();
            chk("R10 sweep begin", xfer_done, 0);
            byte_ack = a; addr_hit = h; nack_rx = n;
            tick();
            byte_ack = 0; addr_hit = 0; nack_rx = 0;
            e = (a & ~d) | h | (n & t);
            chk(d ? "R6 sweep flag" : "R5 sweep flag", irq_flag, e);
            chk("R7 sweep irq", irq, e);
            chk("R10 sweep done", xfer_done, a);
            wr_stat(1, 0);
        end
        sh_dma = 0; sh_ie = 0;
        wr_ctrl(0);
        tick();
        chk("R2 left master", mode_master, 0);

        // R13 nack in slave mode
        sh_tx = 1; wr_ctrl(0);
        nack_rx = 1; tick(); nack_rx = 0;
        chk("R13 slave nack no flag", irq_flag, 0);

        // R9 busy tracking, R5/R13 idle interrupt
        for (int k = 0; k < 2; k++) begin
            sh_idle = k[0]; wr_ctrl(0);
            line_start = 1; tick(); line_start = 0;
            chk("R9 busy set", bus_busy, 1);
            for (int j = 0; j < 4; j++) begin
                tick();
                chk("R9 busy held", bus_busy, 1);
            end
            chk("R9 no flag while busy", irq_flag, 0);
            line_stop = 1; tick(); line_stop = 0;
            chk("R9 busy cleared", bus_busy, 0);
            chk(k == 1 ? "R5 idle flag" : "R13 idle masked", irq_flag, k[0]);
            wr_stat(1, 0);
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            finished = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule